// File: doc/BRIEF.md
# Frequency-Compensated Nanosecond Time Counter

This block keeps a 64-bit time of day in nanoseconds, clocked by a reference clock that runs faster than the nominal tick rate. A 32-bit phase accumulator adds a software-chosen addend on every enabled reference cycle. Each carry out of the accumulator marks one nominal tick, and on that tick the counter advances by a programmable step in nanoseconds. With the addend set to ceil(2^32 × nominal / reference) and the step set to 1e9 / nominal, the counter tracks real time. Software trims the rate in parts per billion by rewriting the addend while the counter runs.

The reported time is the raw counter plus a separate 64-bit offset register. It is registered and refreshed on every reference cycle. Setting absolute time means clearing the offset and then loading the counter. A plain 32-bit register port gives access to the low and high words of the counter, the offset, the addend and a control word. The control word carries the step and the run bit.

The counter load is handled by a two-state machine. In `S_IDLE` nothing is pending. A write of the low counter word takes the `S_IDLE -> S_LO_HELD` transition and parks the value. In `S_LO_HELD` a further low write replaces the parked value. A high write takes the `S_LO_HELD -> S_IDLE` transition and loads both halves on that edge. Reads are made coherent by a shadow: a read of the low word captures the high word, and a later high read returns the captured value.

Top module: `ns_time_counter`

## Requirements
- R1: After reset the counter, offset, addend, control word, shadow and reported time are all zero, and `bus_rvalid_o` is low.
- R2: Register addresses are 0 counter low, 1 counter high, 2 offset low, 3 offset high, 4 addend and 5 control. Control bit 31 is the run bit and control bits [PER_W-1:0] are the step in ns. While the run bit is clear, neither the counter nor the phase accumulator changes.
- R3: On each cycle with the run bit set, the addend is added to the 32-bit phase. When this addition carries out, the counter grows by the step on that same edge. A new addend applies from the cycle after the write.
- R4: The counter is a single 64-bit quantity, so an increment carries from the low word into the high word.
- R5: A write to the counter low word leaves the counter unchanged until the counter high word is written. Both halves then load on the same edge, and the load takes priority over any increment. A high write with no low write pending is ignored.
- R6: A read of the counter low word returns the live low word and captures the live high word into a shadow. A read of the counter high word returns that shadow.
- R7: A read pulse produces `bus_rdata_o` and a one-cycle `bus_rvalid_o` on the following edge. Offset, addend and control read back as written, and addresses 6 and 7 read as zero.
- R8: `tod_o` equals counter plus offset, registered, one cycle after the sum's inputs.
- R9: Each offset word is written on its own and changes only the reported time, never the raw counter.
- R10: Writing zero to the control word stops counting, and the reported time then holds still.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, registered |
| bus_rvalid_o | output | 1 | Read data valid, one cycle per read |
| tod_o | output | 64 | Reported time: counter plus offset, ns |

## Verification
The assertions assume that a read and a write never share a cycle. They also assume that every strobe lasts exactly one reference cycle, so one access is one edge of register activity. The stimulus keeps to this because each access goes through a driver task. The task raises a single strobe at a falling edge, holds it across exactly one rising edge, and clears it before any other access starts. Counting bursts are bounded by control writes placed at known edges, so the bench can predict how many accumulations take place.

// File: rtl/ns_tc_pkg.sv
package ns_tc_pkg;

    typedef enum logic [2:0] {
        A_CNT_LO = 3'd0,
        A_CNT_HI = 3'd1,
        A_OFS_LO = 3'd2,
        A_OFS_HI = 3'd3,
        A_ADDEND = 3'd4,
        A_CTRL   = 3'd5
    } reg_addr_e;

    typedef enum logic {
        S_IDLE,
        S_LO_HELD
    } load_state_e;

    localparam int RUN_BIT = 31;

endpackage

// File: rtl/ns_tc_regs.sv
module ns_tc_regs
    import ns_tc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int PER_W  = 8,
    localparam int CNT_W = 2 * DATA_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [2:0]        addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [CNT_W-1:0]  cnt_i,
    output logic              load_o,
    output logic [CNT_W-1:0]  load_val_o,
    output logic              held_o,
    output logic [CNT_W-1:0]  ofs_o,
    output logic [DATA_W-1:0] addend_o,
    output logic [PER_W-1:0]  period_o,
    output logic              run_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rvalid_o
);

    load_state_e       state_q, state_d;
    logic [DATA_W-1:0] held_lo_q;
    logic [DATA_W-1:0] shadow_hi_q;
    logic [DATA_W-1:0] ofs_lo_q, ofs_hi_q;
    logic [DATA_W-1:0] addend_q;
    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] rdata_q;
    logic              rvalid_q;
    reg_addr_e         addr;

    assign addr = reg_addr_e'(addr_i);

    // state register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= S_IDLE;
        else         state_q <= state_d;
    end

    // next state and load strobe
    always_comb begin
        state_d = state_q;
        load_o  = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (wr_i && addr == A_CNT_LO) state_d = S_LO_HELD;
            end
            S_LO_HELD: begin
                if (wr_i && addr == A_CNT_HI) begin
                    load_o  = 1'b1;
                    state_d = S_IDLE;
                end
            end
        endcase
    end

    assign load_val_o = {wdata_i, held_lo_q};
    assign held_o     = (state_q == S_LO_HELD);

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            held_lo_q <= '0;
            ofs_lo_q  <= '0;
            ofs_hi_q  <= '0;
            addend_q  <= '0;
            ctrl_q    <= '0;
        end else if (wr_i) begin
            case (addr)
                A_CNT_LO: held_lo_q <= wdata_i;
                A_OFS_LO: ofs_lo_q  <= wdata_i;
                A_OFS_HI: ofs_hi_q  <= wdata_i;
                A_ADDEND: addend_q  <= wdata_i;
                A_CTRL:   ctrl_q    <= wdata_i;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            rdata_q     <= '0;
            rvalid_q    <= 1'b0;
            shadow_hi_q <= '0;
        end else begin
            rvalid_q <= rd_i;
            if (rd_i) begin
                case (addr)
                    A_CNT_LO: begin
                        rdata_q     <= cnt_i[DATA_W-1:0];
                        shadow_hi_q <= cnt_i[CNT_W-1:DATA_W];
                    end
                    A_CNT_HI: rdata_q <= shadow_hi_q;
                    A_OFS_LO: rdata_q <= ofs_lo_q;
                    A_OFS_HI: rdata_q <= ofs_hi_q;
                    A_ADDEND: rdata_q <= addend_q;
                    A_CTRL:   rdata_q <= ctrl_q;
                    default:  rdata_q <= '0;
                endcase
            end
        end
    end

    assign ofs_o    = {ofs_hi_q, ofs_lo_q};
    assign addend_o = addend_q;
    assign period_o = ctrl_q[PER_W-1:0];
    assign run_o    = ctrl_q[RUN_BIT];
    assign rdata_o  = rdata_q;
    assign rvalid_o = rvalid_q;

endmodule

// File: rtl/ns_tc_phase.sv
module ns_tc_phase #(
    parameter int ACC_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic [ACC_W-1:0] addend_i,
    output logic             tick_o
);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W:0]   sum;

    assign sum    = {1'b0, acc_q} + {1'b0, addend_i};
    assign tick_o = run_i & sum[ACC_W];

    always_ff @(posedge clk_i) begin
        if (!rst_ni)    acc_q <= '0;
        else if (run_i) acc_q <= sum[ACC_W-1:0];
    end

endmodule

// File: rtl/ns_tc_count.sv
module ns_tc_count #(
    parameter int CNT_W = 64,
    parameter int PER_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic [PER_W-1:0] period_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic [CNT_W-1:0] ofs_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] tod_o
);

    logic [CNT_W-1:0] cnt_q, tod_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni)     cnt_q <= '0;
        else if (load_i) cnt_q <= load_val_i;
        else if (tick_i) cnt_q <= cnt_q + CNT_W'(period_i);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) tod_q <= '0;
        else         tod_q <= cnt_q + ofs_i;
    end

    assign cnt_o = cnt_q;
    assign tod_o = tod_q;

endmodule

// File: rtl/ns_time_counter.sv
module ns_time_counter #(
    parameter int DATA_W = 32,
    parameter int PER_W  = 8,
    localparam int CNT_W = 2 * DATA_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [2:0]        bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              bus_rvalid_o,
    output logic [CNT_W-1:0]  tod_o
);

    logic              load_w, held_w, run_w, tick_w;
    logic [CNT_W-1:0]  load_val_w, ofs_w, cnt_w;
    logic [DATA_W-1:0] addend_w;
    logic [PER_W-1:0]  per_w;

    ns_tc_regs #(.DATA_W(DATA_W), .PER_W(PER_W)) u_regs (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_i       (bus_wr_i),
        .rd_i       (bus_rd_i),
        .addr_i     (bus_addr_i),
        .wdata_i    (bus_wdata_i),
        .cnt_i      (cnt_w),
        .load_o     (load_w),
        .load_val_o (load_val_w),
        .held_o     (held_w),
        .ofs_o      (ofs_w),
        .addend_o   (addend_w),
        .period_o   (per_w),
        .run_o      (run_w),
        .rdata_o    (bus_rdata_o),
        .rvalid_o   (bus_rvalid_o)
    );

    ns_tc_phase #(.ACC_W(DATA_W)) u_phase (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .run_i    (run_w),
        .addend_i (addend_w),
        .tick_o   (tick_w)
    );

    ns_tc_count #(.CNT_W(CNT_W), .PER_W(PER_W)) u_count (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .tick_i     (tick_w),
        .period_i   (per_w),
        .load_i     (load_w),
        .load_val_i (load_val_w),
        .ofs_i      (ofs_w),
        .cnt_o      (cnt_w),
        .tod_o      (tod_o)
    );

endmodule

// File: rtl/ns_tc_checker.sv
module ns_tc_checker #(
    parameter int DATA_W = 32,
    parameter int PER_W  = 8,
    localparam int CNT_W = 2 * DATA_W
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             bus_rd_i,
    input logic             bus_rvalid_o,
    input logic             run,
    input logic             load,
    input logic             held,
    input logic [PER_W-1:0] period,
    input logic [CNT_W-1:0] cnt
);

    // R2: with the run bit clear and no load, the counter stays put
    a_r2_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!run && !load) |=> $stable(cnt));

    // R3: a running counter either holds or advances by exactly one step
    a_r3_one_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run && !load) |=> (cnt == $past(cnt) || cnt == $past(cnt) + CNT_W'($past(period))));

    // R5: a counter load happens only while a low word is parked
    a_r5_load_needs_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load |-> held);

    // R7: each read strobe yields valid data on the next cycle
    a_r7_read_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_rd_i |=> bus_rvalid_o);

    // R7: no valid without a read strobe one cycle earlier
    a_r7_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !bus_rd_i |=> !bus_rvalid_o);

endmodule

bind ns_time_counter ns_tc_checker #(.DATA_W(DATA_W), .PER_W(PER_W)) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .bus_rd_i     (bus_rd_i),
    .bus_rvalid_o (bus_rvalid_o),
    .run          (run_w),
    .load         (load_w),
    .held         (held_w),
    .period       (per_w),
    .cnt          (cnt_w)
);

// File: tb/sim_ns_time_counter.sv
module sim_ns_time_counter;
    import ns_tc_pkg::*;

    localparam int CLK_NS = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr = 1'b0, rd = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rvalid;
    logic [63:0] tod;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] exp;
        logic [31:0] mask;
        string       tag;
    } rd_item_t;
    rd_item_t rq[$];

    // independent model of the time base
    logic [31:0] m_acc = '0;
    logic [31:0] m_add = '0;
    logic [63:0] m_cnt = '0;

    always #(CLK_NS/2) clk = ~clk;

    ns_time_counter u0 (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .bus_wr_i     (wr),
        .bus_rd_i     (rd),
        .bus_addr_i   (addr),
        .bus_wdata_i  (wdata),
        .bus_rdata_o  (rdata),
        .bus_rvalid_o (rvalid),
        .tod_o        (tod)
    );

    task automatic check64(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input reg_addr_e a, input logic [31:0] d);
        wr = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, input logic [31:0] exp, input logic [31:0] mask, input string tag);
        rd_item_t it;
        it.exp = exp; it.mask = mask; it.tag = tag;
        rq.push_back(it);
        rd = 1'b1; addr = a;
        @(posedge clk);
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic model_run(input int n, input logic [7:0] per);
        for (int i = 0; i < n; i++) begin
            logic [32:0] s;
            s = {1'b0, m_acc} + {1'b0, m_add};
            m_acc = s[31:0];
            if (s[32]) m_cnt = m_cnt + 64'(per);
        end
    endtask

    // run for k+1 accumulations, then clear the control word
    task automatic burst(input logic [7:0] per, input int k);
        bus_write(A_CTRL, 32'h8000_0000 | 32'(per));
        repeat (k) @(negedge clk);
        bus_write(A_CTRL, 32'h0);
        model_run(k + 1, per);
    endtask

    task automatic read_cnt(input string tag);
        bus_read(A_CNT_LO, m_cnt[31:0], 32'hFFFF_FFFF, tag);
        bus_read(A_CNT_HI, m_cnt[63:32], 32'hFFFF_FFFF, tag);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && rvalid && !done) begin
            if (rq.size() == 0) begin
                checks++; errors++;
                $display("FAIL R7 unexpected rvalid actual=%h expected=none", rdata);
            end else begin
                rd_item_t it;
                it = rq.pop_front();
                check64(((rdata ^ it.exp) & it.mask) == 0, it.tag, 64'(rdata), 64'(it.exp));
            end
        end
    end

    initial begin
        #(CLK_NS * 100000);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] t0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check64(tod == 0, "R1 tod", tod, 0);
        check64(rvalid == 0, "R1 rvalid", 64'(rvalid), 0);
        for (int a = 0; a < 6; a++) bus_read(3'(a), 32'h0, 32'hFFFF_FFFF, "R1 reg zero");
        bus_read(3'd7, 32'h0, 32'hFFFF_FFFF, "R7 unmapped");

        // R2 run bit clear: nothing counts
        bus_write(A_ADDEND, 32'h8000_0000); m_add = 32'h8000_0000;
        bus_write(A_CTRL, 32'h0000_0008);
        repeat (10) @(negedge clk);
        bus_read(A_CNT_LO, 32'h0, 32'hFFFF_FFFF, "R2 no count");
        bus_read(A_CTRL, 32'h0000_0008, 32'hFFFF_FFFF, "R7 ctrl readback");
        bus_read(A_ADDEND, 32'h8000_0000, 32'hFFFF_FFFF, "R7 addend readback");

        // R3 carry-driven stepping
        burst(8'd8, 19);
        check64(m_cnt == 64'd80, "R3 model sanity", m_cnt, 64'd80);
        read_cnt("R3 count");
        repeat (2) @(negedge clk);
        check64(tod == m_cnt, "R8 tod follows counter", tod, m_cnt);

        // R3 addend change
        bus_write(A_ADDEND, 32'h4000_0000); m_add = 32'h4000_0000;
        burst(8'd3, 6);
        read_cnt("R3 new addend");

        // R9 offset
        bus_write(A_OFS_LO, 32'd5);
        bus_write(A_OFS_HI, 32'd1);
        repeat (3) @(negedge clk);
        check64(tod == m_cnt + 64'h1_0000_0005, "R9 tod with offset", tod, m_cnt + 64'h1_0000_0005);
        bus_read(A_OFS_LO, 32'd5, 32'hFFFF_FFFF, "R9 ofs lo");
        bus_read(A_OFS_HI, 32'd1, 32'hFFFF_FFFF, "R9 ofs hi");
        read_cnt("R9 raw counter untouched");

        // R5 paired load
        bus_write(A_CNT_LO, 32'hFFFF_FFF0);
        bus_read(A_CNT_LO, m_cnt[31:0], 32'hFFFF_FFFF, "R5 low held");
        bus_write(A_CNT_HI, 32'd2); m_cnt = 64'h2_FFFF_FFF0;
        read_cnt("R5 loaded");
        bus_write(A_CNT_HI, 32'd7);
        read_cnt("R5 lone high ignored");

        // R4 carry into the high word
        bus_write(A_OFS_LO, 32'd0);
        bus_write(A_OFS_HI, 32'd0);
        bus_write(A_ADDEND, 32'h8000_0000); m_add = 32'h8000_0000;
        burst(8'h10, 1);
        read_cnt("R4 word carry");
        repeat (2) @(negedge clk);
        check64(tod == 64'h3_0000_0000, "R4 tod", tod, 64'h3_0000_0000);

        // R10 stopped after clear
        t0 = tod;
        repeat (10) @(negedge clk);
        check64(tod == t0, "R10 stopped", tod, t0);

        // R6 coherent split read, R5 load over increment
        bus_write(A_ADDEND, 32'hFFFF_FFFF);
        bus_write(A_CTRL, 32'h8000_0008);
        bus_write(A_CNT_LO, 32'hFFFF_FFC0);
        bus_write(A_CNT_HI, 32'h0);
        bus_read(A_CNT_LO, 32'hFFFF_FFC0, 32'hFFFF_FFFF, "R5 load wins over step");
        repeat (20) @(negedge clk);
        bus_read(A_CNT_HI, 32'h0, 32'hFFFF_FFFF, "R6 shadow high");
        bus_write(A_CTRL, 32'h0);
        bus_read(A_CNT_LO, 32'h0, 32'h0, "R6 live low");
        bus_read(A_CNT_HI, 32'h1, 32'hFFFF_FFFF, "R6 new shadow");

        repeat (3) @(negedge clk);
        check64(rq.size() == 0, "R7 all reads answered", 64'(rq.size()), 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule